// File: doc/BRIEF.md
# Banked Chip-Select Address Decoder

This block decides which of twelve programmable memory banks an access on the system bus belongs to. Each bank holds two configuration words. The base word carries a 17-bit address tag, a port width, a write-protect flag, a 3-bit timing-engine selector and an enable flag. The option word carries a 17-bit tag mask. When the bus presents a valid address, the block compares its upper 17 bits with every enabled bank under that bank's mask. One clock edge later it drives a single active-low chip select and the winning bank's attributes. A downstream timing engine uses those attributes to pick its sequencer and its data width.

Out of reset no bank has been configured, so bank 0 acts as a catch-all boot select that claims every address. The catch-all mode is left only when bank 0's option word is written at some point after its base word. This lets boot firmware move the boot region without losing it part-way through the change. Firmware programs the banks through a simple write port and can read any word back through a combinational read port.

Top module: `membank_select`

## Requirements
- R1: While reset is held and on the first cycles after it, every chip select is high (`csN` = 12'hFFF) and `hit` and `wpErr` are 0.
- R2: In boot mode, any valid access asserts `csN[0]` (and no other select), with `portSize` = 2'b11 and `machSel` = 3'b000. This holds whatever bank 0's registers contain.
- R3: Boot mode ends only when bank 0's option word is written while a bank 0 base write has already taken place since reset. An option write to bank 0 with no earlier base write leaves boot mode on.
- R4: A bank hits when, for every bit set in its mask (option bits 31:15), address bit n equals base tag bit n (base bits 31:15). Address bits 14:0 never affect the decode.
- R5: A bank whose enable flag (base bit 0) is 0 never hits.
- R6: When several banks hit, only the lowest-numbered one is selected, and at most one `csN` bit is ever low.
- R7: On a hit, `portSize` shows base bits 12:11 and `machSel` shows base bits 7:5 of the winning bank. On a miss, both are 0 and `hit` is 0.
- R8: If the winning bank's write-protect flag (base bit 8) is 1, a write leaves all `csN` high and raises `wpErr`, with `hit` = 1. A read to that bank asserts its select with `wpErr` = 0.
- R9: Reading back a word returns 0 in every reserved position. Base bits 14:13, 10:9 and 4:1 are reserved. Option bits 14:0 are reserved. Reads of bank numbers 12 to 15 return 0, and writes to those bank numbers change nothing.
- R10: The outputs appear exactly one clock edge after the edge that samples `busValid`. In a cycle after an edge with `busValid` low, all selects are high and `hit` and `wpErr` are 0. Back-to-back valid cycles each give their own result.
- R11: An option mask of 0xFF80_0000 gives an 8 MB window: 0xFF80_0000 through 0xFFFF_FFFF hit a bank based at 0xFF80_0000, and 0xFF7F_FFFC does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgIsOpt | input | 1 | 1 selects the option word, 0 the base word (write and read back) |
| cfgBank | input | 4 | Bank number for write and read back |
| cfgData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Read-back of the addressed word, reserved bits zero |
| busValid | input | 1 | Address valid for this cycle |
| busAddr | input | 32 | Bus address |
| busWrite | input | 1 | 1 for a write access, 0 for a read |
| csN | output | 12 | Active-low chip select per bank |
| portSize | output | 2 | Port width code of the selected bank |
| machSel | output | 3 | Timing-engine selector of the selected bank |
| wpErr | output | 1 | Write hit a write-protected bank |
| hit | output | 1 | Some bank matched the access |

## Verification
Every decode result is due at the falling edge that follows the rising edge sampling `busValid`. The monitor records `busValid` at each rising edge and compares the outputs half a cycle later. An access has therefore failed if its result arrives early or late. Idle cycles are checked the same way against the all-high state. Configuration writes take effect at the rising edge that samples `cfgWe`, so the first access that may use them is driven at the next falling edge. Read-back is combinational and is compared 1 ns after the bank number changes.

// File: rtl/membank_pkg.sv
package membank_pkg;
  localparam int BANKS   = 12;
  localparam int ADDR_W  = 32;
  localparam int TAG_W   = 17;
  localparam int IDX_W   = 4;
  localparam int LOW_W   = ADDR_W - TAG_W;
  localparam logic [1:0] BOOT_PS = 2'b11;
  localparam logic [2:0] BOOT_MS = 3'b000;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [1:0]       ps;
    logic             wp;
    logic [2:0]       ms;
    logic             valid;
  } baseReg_t;

  typedef struct packed {
    logic [BANKS-1:0] wrBase;
    logic [BANKS-1:0] wrOpt;
    logic             bootMode;
  } bankStrobe_t;

  function automatic baseReg_t unpackBase(input logic [ADDR_W-1:0] d);
    baseReg_t b;
    b.tag   = d[31:15];
    b.ps    = d[12:11];
    b.wp    = d[8];
    b.ms    = d[7:5];
    b.valid = d[0];
    return b;
  endfunction

  function automatic logic [ADDR_W-1:0] packBase(input baseReg_t b);
    return {b.tag, 2'b00, b.ps, 2'b00, b.wp, b.ms, 4'b0000, b.valid};
  endfunction
endpackage

// File: rtl/membank_ctrl.sv
module membank_ctrl
  import membank_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic             cfgIsOpt,
  input  logic [IDX_W-1:0] cfgBank,
  output bankStrobe_t      strobe
);
  logic baseSeen;
  logic bootMode;

  for (genvar i = 0; i < BANKS; i++) begin : g_dec
    assign strobe.wrBase[i] = cfgWe && !cfgIsOpt && (cfgBank == IDX_W'(i));
    assign strobe.wrOpt[i]  = cfgWe &&  cfgIsOpt && (cfgBank == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseSeen <= 1'b0;
      bootMode <= 1'b1;
    end else begin
      if (strobe.wrBase[0]) baseSeen <= 1'b1;
      if (strobe.wrOpt[0] && baseSeen) bootMode <= 1'b0;
    end
  end

  assign strobe.bootMode = bootMode;

  // R3: boot mode may only end on an option write to bank 0
  a_r3_boot_exit: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bootMode) |-> $past(cfgWe && cfgIsOpt && cfgBank == '0));

  // R3: option write before any base write keeps boot mode
  a_r3_boot_hold: assert property (@(posedge clk) disable iff (!rstN)
    (bootMode && !baseSeen && !(cfgWe && !cfgIsOpt && cfgBank == '0)) |=> bootMode);
endmodule

// File: rtl/membank_dp.sv
module membank_dp
  import membank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobe_t       strobe,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              cfgIsOpt,
  input  logic [IDX_W-1:0]  cfgBank,
  output logic [ADDR_W-1:0] cfgRdData,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  output logic [BANKS-1:0]  csN,
  output logic [1:0]        portSize,
  output logic [2:0]        machSel,
  output logic              wpErr,
  output logic              hit
);
  baseReg_t         baseQ [BANKS];
  logic [TAG_W-1:0] maskQ [BANKS];
  logic [BANKS-1:0] match;
  logic [TAG_W-1:0] addrTag;

  assign addrTag = busAddr[ADDR_W-1:LOW_W];

  for (genvar i = 0; i < BANKS; i++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ[i] <= '0;
        maskQ[i] <= '0;
      end else begin
        if (strobe.wrBase[i]) baseQ[i] <= unpackBase(cfgData);
        if (strobe.wrOpt[i])  maskQ[i] <= cfgData[ADDR_W-1:LOW_W];
      end
    end
    if (i == 0) begin : g_boot
      assign match[i] = strobe.bootMode ||
        (baseQ[i].valid && (((addrTag ^ baseQ[i].tag) & maskQ[i]) == '0));
    end else begin : g_norm
      assign match[i] =
        baseQ[i].valid && (((addrTag ^ baseQ[i].tag) & maskQ[i]) == '0);
    end
  end

  // lowest-numbered matching bank wins
  logic [BANKS-1:0] winOh;
  logic [1:0]       winPs;
  logic [2:0]       winMs;
  logic             winWp;
  always_comb begin
    winOh = '0;
    winPs = '0;
    winMs = '0;
    winWp = 1'b0;
    for (int i = BANKS - 1; i >= 0; i--) begin
      if (match[i]) begin
        winOh = '0;
        winOh[i] = 1'b1;
        winPs = baseQ[i].ps;
        winMs = baseQ[i].ms;
        winWp = baseQ[i].wp;
      end
    end
    if (strobe.bootMode && match[0]) begin
      winPs = BOOT_PS;
      winMs = BOOT_MS;
      winWp = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN      <= '1;
      portSize <= '0;
      machSel  <= '0;
      wpErr    <= 1'b0;
      hit      <= 1'b0;
    end else if (busValid && (|match)) begin
      csN      <= (winWp && busWrite) ? '1 : ~winOh;
      portSize <= winPs;
      machSel  <= winMs;
      wpErr    <= winWp && busWrite;
      hit      <= 1'b1;
    end else begin
      csN      <= '1;
      portSize <= '0;
      machSel  <= '0;
      wpErr    <= 1'b0;
      hit      <= 1'b0;
    end
  end

  always_comb begin
    cfgRdData = '0;
    if (cfgBank < IDX_W'(BANKS)) begin
      if (cfgIsOpt) cfgRdData = {maskQ[cfgBank], {LOW_W{1'b0}}};
      else          cfgRdData = packBase(baseQ[cfgBank]);
    end
  end

  // R6: never more than one select low
  a_r6_single_cs: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  // R8: a protected write reports an error and drives no select
  a_r8_wp_no_cs: assert property (@(posedge clk) disable iff (!rstN)
    wpErr |-> (&csN) && hit);

  // R10: idle cycle yields idle outputs one edge later
  a_r10_idle_out: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> (&csN) && !hit && !wpErr);

  // R2: boot mode access selects bank 0 on the next edge
  a_r2_boot_cs0: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bootMode && busValid) |=> !csN[0] && portSize == BOOT_PS);

  // R9: reserved read-back positions are zero
  a_r9_rsvd_zero: assert property (@(posedge clk) disable iff (!rstN)
    cfgIsOpt ? (cfgRdData[LOW_W-1:0] == '0)
             : ((cfgRdData & 32'h0000_661E) == '0));
endmodule

// File: rtl/membank_select.sv
module membank_select
  import membank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgIsOpt,
  input  logic [IDX_W-1:0]  cfgBank,
  input  logic [ADDR_W-1:0] cfgData,
  output logic [ADDR_W-1:0] cfgRdData,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  output logic [BANKS-1:0]  csN,
  output logic [1:0]        portSize,
  output logic [2:0]        machSel,
  output logic              wpErr,
  output logic              hit
);
  bankStrobe_t strobe;

  membank_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgIsOpt (cfgIsOpt),
    .cfgBank  (cfgBank),
    .strobe   (strobe)
  );

  membank_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgData   (cfgData),
    .cfgIsOpt  (cfgIsOpt),
    .cfgBank   (cfgBank),
    .cfgRdData (cfgRdData),
    .busValid  (busValid),
    .busAddr   (busAddr),
    .busWrite  (busWrite),
    .csN       (csN),
    .portSize  (portSize),
    .machSel   (machSel),
    .wpErr     (wpErr),
    .hit       (hit)
  );
endmodule

// File: tb/membank_select_test.sv
module membank_select_test;
  import membank_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rstN = 1'b0;
  logic              cfgWe = 1'b0, cfgIsOpt = 1'b0;
  logic [IDX_W-1:0]  cfgBank = '0;
  logic [ADDR_W-1:0] cfgData = '0;
  logic [ADDR_W-1:0] cfgRdData;
  logic              busValid = 1'b0, busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [BANKS-1:0]  csN;
  logic [1:0]        portSize;
  logic [2:0]        machSel;
  logic              wpErr, hit;

  membank_select uut (.*);

  typedef struct packed {
    logic [BANKS-1:0] cs;
    logic [1:0]       ps;
    logic [2:0]       ms;
    logic             wp;
    logic             hit;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int    checks = 0, fails = 0;
  bit    monOn = 1'b0, finished = 1'b0;

  function automatic exp_t mk(input int bank, input logic [1:0] ps,
                              input logic [2:0] ms, input logic wp);
    exp_t e;
    e.cs  = '1;
    e.ps  = (bank < 0) ? 2'b00 : ps;
    e.ms  = (bank < 0) ? 3'b000 : ms;
    e.wp  = wp;
    e.hit = (bank >= 0);
    if (bank >= 0 && !wp) e.cs[bank] = 1'b0;
    return e;
  endfunction

  function automatic exp_t got();
    exp_t g;
    g.cs = csN; g.ps = portSize; g.ms = machSel; g.wp = wpErr; g.hit = hit;
    return g;
  endfunction

  task automatic compare(input exp_t e, input string tag);
    exp_t g = got();
    checks++;
    if (g !== e) begin
      fails++;
      $display("FAIL %s: got cs=%h ps=%b ms=%b wp=%b hit=%b exp cs=%h ps=%b ms=%b wp=%b hit=%b",
               tag, g.cs, g.ps, g.ms, g.wp, g.hit, e.cs, e.ps, e.ms, e.wp, e.hit);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic w, input exp_t e, input string tag);
    @(negedge clk);
    busValid = 1'b1; busAddr = a; busWrite = w;
    expQ.push_back(e); tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      busValid = 1'b0; busWrite = 1'b0;
    end
  endtask

  task automatic cfgWrite(input int bank, input logic opt, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b0;
    cfgWe = 1'b1; cfgIsOpt = opt; cfgBank = IDX_W'(bank); cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic readBack(input int bank, input logic opt, input logic [31:0] e, input string tag);
    @(negedge clk);
    cfgBank = IDX_W'(bank); cfgIsOpt = opt;
    #1;
    checks++;
    if (cfgRdData !== e) begin
      fails++;
      $display("FAIL %s: got %h exp %h", tag, cfgRdData, e);
    end
  endtask

  // monitor: result due at the negedge following the sampling posedge
  initial begin
    forever begin
      bit saw;
      @(posedge clk);
      saw = busValid && rstN;
      @(negedge clk);
      #1;
      if (monOn) begin
        if (saw) begin
          if (expQ.size() == 0) begin
            checks++; fails++;
            $display("FAIL R10: result with no expected item");
          end else compare(expQ.pop_front(), tagQ.pop_front());
        end else compare(mk(-1, 2'b00, 3'b000, 1'b0), "R10 idle");
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, exp completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(mk(-1, 2'b00, 3'b000, 1'b0), "R1 during reset");
    rstN = 1'b1;
    @(negedge clk); #1;
    compare(mk(-1, 2'b00, 3'b000, 1'b0), "R1 after reset");
    monOn = 1'b1;

    // R2 boot mode catch-all, back-to-back (R10)
    access(32'h1234_5678, 1'b0, mk(0, 2'b11, 3'b000, 1'b0), "R2 boot read");
    access(32'h0000_0000, 1'b1, mk(0, 2'b11, 3'b000, 1'b0), "R2 R10 boot back-to-back");
    idle(2);

    // R3: option before base keeps boot mode; R9 option reserved bits
    cfgWrite(0, 1'b1, 32'hFF80_7FFF);
    readBack(0, 1'b1, 32'hFF80_0000, "R9 option readback");
    access(32'h4000_0000, 1'b0, mk(0, 2'b11, 3'b000, 1'b0), "R3 opt-first stays boot");
    idle(1);
    cfgWrite(0, 1'b0, 32'hFF80_1801);
    access(32'h4000_0000, 1'b0, mk(0, 2'b11, 3'b000, 1'b0), "R3 base-after-opt stays boot");
    idle(1);
    cfgWrite(0, 1'b1, 32'hFF80_0000);
    access(32'h4000_0000, 1'b0, mk(-1, 2'b00, 3'b000, 1'b0), "R3 boot exited miss");
    access(32'hFF80_1234, 1'b0, mk(0, 2'b11, 3'b000, 1'b0), "R11 window low");
    access(32'hFFFF_FFFC, 1'b1, mk(0, 2'b11, 3'b000, 1'b0), "R11 window top");
    access(32'hFF7F_FFFC, 1'b0, mk(-1, 2'b00, 3'b000, 1'b0), "R11 below window");
    idle(1);

    // R4/R7: bank 1, full mask, ps 01, ms 010
    cfgWrite(1, 1'b1, 32'hFFFF_8000);
    cfgWrite(1, 1'b0, 32'h0450_0841);
    access(32'h0450_7FF0, 1'b0, mk(1, 2'b01, 3'b010, 1'b0), "R4 R7 low bits ignored");
    access(32'h0450_8000, 1'b0, mk(-1, 2'b00, 3'b000, 1'b0), "R4 tag bit differs");
    idle(1);

    // R5: disabled bank 3
    cfgWrite(3, 1'b1, 32'hF000_0000);
    cfgWrite(3, 1'b0, 32'h2000_0000);
    access(32'h2000_0000, 1'b0, mk(-1, 2'b00, 3'b000, 1'b0), "R5 disabled bank");
    idle(1);

    // R6: overlaps
    cfgWrite(5, 1'b1, 32'hFF80_0000);
    cfgWrite(5, 1'b0, 32'hFF80_1021);
    access(32'hFF80_0000, 1'b0, mk(0, 2'b11, 3'b000, 1'b0), "R6 bank0 over bank5");
    cfgWrite(4, 1'b1, 32'hF000_0000);
    cfgWrite(4, 1'b0, 32'h8000_1001);
    cfgWrite(7, 1'b1, 32'hFF80_0000);
    cfgWrite(7, 1'b0, 32'h8800_0861);
    access(32'h8800_0000, 1'b0, mk(4, 2'b10, 3'b000, 1'b0), "R6 bank4 over bank7");
    access(32'h9000_0000, 1'b0, mk(-1, 2'b00, 3'b000, 1'b0), "R4 outside bank4");
    idle(1);

    // R8: write protect on bank 6
    cfgWrite(6, 1'b1, 32'hF000_0000);
    cfgWrite(6, 1'b0, 32'h3000_1901);
    access(32'h3000_0010, 1'b0, mk(6, 2'b11, 3'b000, 1'b0), "R8 protected read");
    access(32'h3000_0010, 1'b1, mk(6, 2'b11, 3'b000, 1'b1), "R8 protected write");
    access(32'h0450_0000, 1'b1, mk(1, 2'b01, 3'b010, 1'b0), "R8 unprotected write");
    idle(1);

    // R9: base reserved bits, out-of-range bank
    cfgWrite(11, 1'b0, 32'hFFFF_FFFE);
    readBack(11, 1'b0, 32'hFFFF_99E0, "R9 base readback");
    cfgWrite(13, 1'b0, 32'hFFFF_FFFF);
    readBack(13, 1'b0, 32'h0000_0000, "R9 out-of-range bank");
    access(32'h9000_0000, 1'b0, mk(-1, 2'b00, 3'b000, 1'b0), "R9 out-of-range write no effect");
    idle(3);

    if (expQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL R10: %0d results missing, exp 0", expQ.size());
    end
    finish();
  end
endmodule